// File: doc/BRIEF.md
# Monitor Channel Command Framing Engine

This block sits between the bit-level line interface of a time-division monitor channel and a register access back end. One monitor channel is shared by two voice sub-channels, A and B. Every frame carries one downstream byte, and a byte counts only once it has arrived in two consecutive frames. The engine checks that a message opens with a valid start byte, extracts the addressed sub-channel, passes the command byte and its data bytes to the back end, and recognises the two-byte identification request.

Upstream, the engine builds the reply messages. A read reply has a start byte that tags the source sub-channel, followed by 1 to 16 data bytes pulled from the back end. An identification reply is a fixed two-byte code. Each reply byte is shown for two frames. When nothing is pending, the upstream line carries the idle pattern.

Top module: `mon_frame_engine`

## Requirements
- R1: On a frame where `dn_eom` is 0, a downstream byte is accepted only when the previous frame carried the same value. After an accepted pair the comparison starts fresh. On a mismatch, the new byte becomes the first copy of a new pair.
- R2: The first accepted byte of a message must be 81h or 91h; bit 4 gives the sub-channel (0 = A, 1 = B). Any other first byte except 80h makes the engine ignore the rest of the message.
- R3: The accepted byte after the start byte is the command. `cmd_vld` pulses one cycle after the frame strobe that completed it, with `cmd_byte` and `cmd_chan_b` equal to start-byte bit 4.
- R4: For a global command (command bits 6:5 = 01), `cmd_chan_b` is 0 whatever the start byte said.
- R5: A command with bits 6:5 = 10 is not forwarded, and the rest of that message is ignored.
- R6: Accepted bytes after the command pulse `data_vld` one cycle after their strobe. At most 4 are forwarded for command bits 6:5 = 00 or 01, and at most 16 for 11. Further bytes are ignored.
- R7: A frame strobe with `dn_eom` = 1 ends the message. The byte of that frame is discarded, any half-received pair is dropped, and the next accepted byte is treated as a start byte.
- R8: A message whose first two accepted bytes are 80h then 00h gets the upstream reply 80h, 82h.
- R9: A `rsp_start` pulse queues a read reply. The reply is a start byte (81h if `rsp_chan_b` = 0, 91h if 1), then `rsp_len`+1 data bytes. Each data byte is taken from `rsp_data` in the cycle that `rsp_rd` pulses.
- R10: `up_byte` changes only at the clock edge of a strobe cycle, and each reply byte is held for exactly two frames.
- R11: `up_byte` is FFh after reset and whenever no reply is being sent. At least one FFh frame separates two replies.
- R12: A reply request (read or identification) that arrives while another reply is queued or being sent is dropped.
- R13: After reset, `cmd_vld` and `data_vld` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_stb | input | 1 | One-cycle pulse per monitor frame |
| dn_byte | input | 8 | Downstream monitor byte, valid with `frm_stb` |
| dn_eom | input | 1 | End-of-message / line idle, sampled with `frm_stb` |
| cmd_vld | output | 1 | Command byte pulse |
| cmd_byte | output | 8 | Forwarded command byte |
| cmd_chan_b | output | 1 | Addressed sub-channel (1 = B) |
| data_vld | output | 1 | Data byte pulse |
| data_byte | output | 8 | Forwarded data byte |
| rsp_start | input | 1 | Back end requests a read reply |
| rsp_chan_b | input | 1 | Source sub-channel of the read reply |
| rsp_len | input | 4 | Number of reply data bytes minus one |
| rsp_data | input | 8 | Head of the back end's reply data |
| rsp_rd | output | 1 | Takes `rsp_data` for the reply |
| up_byte | output | 8 | Upstream monitor byte |

## Verification
If the pairing state is stale, a command or data pulse appears one frame too early, or one that should appear never does; the per-cycle comparison catches this in the cycle after the affected strobe. If the parser drops back to the wrong state, whole messages are lost or misrouted, and this shows at the first `cmd_vld` of the next message. If the reply sequencer is off by one frame or one byte, `up_byte` departs from the modelled frame sequence at the very next strobe. The count of bytes taken from the back end is also compared once at the end.

// File: rtl/mon_pkg.sv
package mon_pkg;
    localparam logic [7:0] START_A     = 8'h81;
    localparam logic [7:0] START_B     = 8'h91;
    localparam logic [7:0] START_MASK  = 8'hEF;
    localparam logic [7:0] IDQ_HI      = 8'h80;
    localparam logic [7:0] IDQ_LO      = 8'h00;
    localparam logic [7:0] IDR_LO      = 8'h82;
    localparam logic [7:0] IDLE_BYTE   = 8'hFF;

    localparam logic [1:0] CT_LOCAL    = 2'b00;
    localparam logic [1:0] CT_GLOBAL   = 2'b01;
    localparam logic [1:0] CT_BAD      = 2'b10;
    localparam logic [1:0] CT_RAM      = 2'b11;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_CMD,
        PS_DATA,
        PS_IDCHK,
        PS_SKIP
    } parse_st_e;
endpackage

// File: rtl/mon_pair_filter.sv
module mon_pair_filter
    import mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frm_stb,
    input  logic       dn_eom,
    input  logic [7:0] dn_byte,
    output logic       acc_vld,
    output logic [7:0] acc_byte
);
    typedef struct packed {
        logic [7:0] cand;
        logic       held;
    } pair_t;

    pair_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        acc_vld  = 1'b0;
        acc_byte = dn_byte;
        if (frm_stb) begin
            if (dn_eom) begin
                r_d.held = 1'b0;
            end else if (r_q.held && (dn_byte == r_q.cand)) begin
                acc_vld  = 1'b1;
                r_d.held = 1'b0;
            end else begin
                r_d.cand = dn_byte;
                r_d.held = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R1: an accepted pair leaves no first copy behind
    p_fresh_after_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld |=> !acc_vld);
    // R7: end-of-message drops a half pair
    p_eom_drops_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_stb && dn_eom) |=> !r_q.held);
endmodule

// File: rtl/mon_msg_parser.sv
module mon_msg_parser
    import mon_pkg::*;
#(
    parameter int REG_MAX = 4,
    parameter int RAM_MAX = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frm_stb,
    input  logic       dn_eom,
    input  logic       acc_vld,
    input  logic [7:0] acc_byte,
    output logic       cmd_vld,
    output logic [7:0] cmd_byte,
    output logic       cmd_chan_b,
    output logic       data_vld,
    output logic [7:0] data_byte,
    output logic       id_req
);
    localparam int CW = $clog2(RAM_MAX + 1);

    typedef struct packed {
        parse_st_e   st;
        logic        chan;
        logic [CW-1:0] cnt;
        logic [CW-1:0] cap;
        logic        cmd_vld;
        logic [7:0]  cmd;
        logic        cmd_chan;
        logic        data_vld;
        logic [7:0]  data;
        logic        id_req;
    } prs_t;

    prs_t r_q, r_d;

    always_comb begin
        r_d          = r_q;
        r_d.cmd_vld  = 1'b0;
        r_d.data_vld = 1'b0;
        r_d.id_req   = 1'b0;
        if (frm_stb && dn_eom) begin
            r_d.st = PS_IDLE;
        end else if (acc_vld) begin
            case (r_q.st)
                PS_IDLE: begin
                    if ((acc_byte & START_MASK) == START_A) begin
                        r_d.st   = PS_CMD;
                        r_d.chan = acc_byte[4];
                    end else if (acc_byte == IDQ_HI) begin
                        r_d.st = PS_IDCHK;
                    end else begin
                        r_d.st = PS_SKIP;
                    end
                end
                PS_CMD: begin
                    if (acc_byte[6:5] == CT_BAD) begin
                        r_d.st = PS_SKIP;
                    end else begin
                        r_d.st       = PS_DATA;
                        r_d.cmd_vld  = 1'b1;
                        r_d.cmd      = acc_byte;
                        r_d.cmd_chan = (acc_byte[6:5] == CT_GLOBAL) ? 1'b0 : r_q.chan;
                        r_d.cnt      = '0;
                        r_d.cap      = (acc_byte[6:5] == CT_RAM) ? CW'(RAM_MAX) : CW'(REG_MAX);
                    end
                end
                PS_DATA: begin
                    if (r_q.cnt < r_q.cap) begin
                        r_d.data_vld = 1'b1;
                        r_d.data     = acc_byte;
                        r_d.cnt      = r_q.cnt + CW'(1);
                    end else begin
                        r_d.st = PS_SKIP;
                    end
                end
                PS_IDCHK: begin
                    r_d.st     = PS_SKIP;
                    r_d.id_req = (acc_byte == IDQ_LO);
                end
                default: r_d.st = PS_SKIP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cmd_vld    = r_q.cmd_vld;
    assign cmd_byte   = r_q.cmd;
    assign cmd_chan_b = r_q.cmd_chan;
    assign data_vld   = r_q.data_vld;
    assign data_byte  = r_q.data;
    assign id_req     = r_q.id_req;

    // R5: the reserved command type never reaches the back end
    p_no_reserved_type_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld |-> (cmd_byte[6:5] != CT_BAD));
    // R4: global commands carry no sub-channel
    p_global_chan_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_byte[6:5] == CT_GLOBAL) |-> !cmd_chan_b);
    // R6: the data count never passes the cap of its command type
    p_data_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == PS_DATA) |-> (r_q.cnt <= r_q.cap));
    // R7: end-of-message returns to the start-byte state with no pulse
    p_eom_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_stb && dn_eom) |=> (r_q.st == PS_IDLE && !cmd_vld && !data_vld));
endmodule

// File: rtl/mon_reply_gen.sv
module mon_reply_gen
    import mon_pkg::*;
#(
    parameter int RD_MAX = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frm_stb,
    input  logic                      id_req,
    input  logic                      rsp_start,
    input  logic                      rsp_chan_b,
    input  logic [$clog2(RD_MAX)-1:0] rsp_len,
    input  logic [7:0]                rsp_data,
    output logic                      rsp_rd,
    output logic [7:0]                up_byte
);
    localparam int IW = $clog2(RD_MAX + 1);

    typedef struct packed {
        logic          pend;
        logic          pend_id;
        logic          pend_chan;
        logic [IW-1:0] pend_last;
        logic          busy;
        logic          half;
        logic [IW-1:0] idx;
        logic [IW-1:0] last;
        logic          is_id;
        logic [7:0]    up;
    } rep_t;

    rep_t r_q, r_d;

    always_comb begin
        r_d    = r_q;
        rsp_rd = 1'b0;
        if (frm_stb) begin
            if (!r_q.busy) begin
                if (r_q.pend) begin
                    r_d.busy  = 1'b1;
                    r_d.half  = 1'b0;
                    r_d.idx   = '0;
                    r_d.last  = r_q.pend_last;
                    r_d.is_id = r_q.pend_id;
                    r_d.pend  = 1'b0;
                    if (r_q.pend_id)        r_d.up = IDQ_HI;
                    else if (r_q.pend_chan) r_d.up = START_B;
                    else                    r_d.up = START_A;
                end else begin
                    r_d.up = IDLE_BYTE;
                end
            end else if (!r_q.half) begin
                r_d.half = 1'b1;
            end else if (r_q.idx == r_q.last) begin
                r_d.busy = 1'b0;
                r_d.up   = IDLE_BYTE;
            end else begin
                r_d.idx  = r_q.idx + IW'(1);
                r_d.half = 1'b0;
                if (r_q.is_id) begin
                    r_d.up = IDR_LO;
                end else begin
                    r_d.up = rsp_data;
                    rsp_rd = 1'b1;
                end
            end
        end
        if (!r_q.pend && !r_q.busy) begin
            if (id_req) begin
                r_d.pend      = 1'b1;
                r_d.pend_id   = 1'b1;
                r_d.pend_chan = 1'b0;
                r_d.pend_last = IW'(1);
            end else if (rsp_start) begin
                r_d.pend      = 1'b1;
                r_d.pend_id   = 1'b0;
                r_d.pend_chan = rsp_chan_b;
                r_d.pend_last = IW'(rsp_len) + IW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.up <= IDLE_BYTE;
        end else begin
            r_q <= r_d;
        end
    end

    assign up_byte = r_q.up;

    // R10: the first frame of a byte is always followed by a second copy
    p_hold_two_frames_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_stb && r_q.busy && !r_q.half) |=> $stable(up_byte));
    // R10: nothing moves the upstream byte between frames
    p_quiet_between_frames_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_stb |=> $stable(up_byte));
    // R11: idle sequencer shows the idle pattern
    p_idle_pattern_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.busy |-> (up_byte == IDLE_BYTE));
    // R12: a queued request is not overwritten while it waits
    p_keep_pending_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.pend && !frm_stb) |=> ($stable(r_q.pend_last) && r_q.pend));
endmodule

// File: rtl/mon_frame_engine.sv
module mon_frame_engine
    import mon_pkg::*;
#(
    parameter int REG_MAX_BYTES = 4,
    parameter int RAM_MAX_BYTES = 16,
    parameter int RD_MAX_BYTES  = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            frm_stb,
    input  logic [7:0]                      dn_byte,
    input  logic                            dn_eom,
    output logic                            cmd_vld,
    output logic [7:0]                      cmd_byte,
    output logic                            cmd_chan_b,
    output logic                            data_vld,
    output logic [7:0]                      data_byte,
    input  logic                            rsp_start,
    input  logic                            rsp_chan_b,
    input  logic [$clog2(RD_MAX_BYTES)-1:0] rsp_len,
    input  logic [7:0]                      rsp_data,
    output logic                            rsp_rd,
    output logic [7:0]                      up_byte
);
    logic       acc_vld;
    logic [7:0] acc_byte;
    logic       id_req;

    mon_pair_filter i_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .frm_stb  (frm_stb),
        .dn_eom   (dn_eom),
        .dn_byte  (dn_byte),
        .acc_vld  (acc_vld),
        .acc_byte (acc_byte)
    );

    mon_msg_parser #(
        .REG_MAX (REG_MAX_BYTES),
        .RAM_MAX (RAM_MAX_BYTES)
    ) i_parse (
        .clk        (clk),
        .rst_n      (rst_n),
        .frm_stb    (frm_stb),
        .dn_eom     (dn_eom),
        .acc_vld    (acc_vld),
        .acc_byte   (acc_byte),
        .cmd_vld    (cmd_vld),
        .cmd_byte   (cmd_byte),
        .cmd_chan_b (cmd_chan_b),
        .data_vld   (data_vld),
        .data_byte  (data_byte),
        .id_req     (id_req)
    );

    mon_reply_gen #(
        .RD_MAX (RD_MAX_BYTES)
    ) i_reply (
        .clk        (clk),
        .rst_n      (rst_n),
        .frm_stb    (frm_stb),
        .id_req     (id_req),
        .rsp_start  (rsp_start),
        .rsp_chan_b (rsp_chan_b),
        .rsp_len    (rsp_len),
        .rsp_data   (rsp_data),
        .rsp_rd     (rsp_rd),
        .up_byte    (up_byte)
    );

    // R3: a command pulse is always the result of the preceding frame
    p_cmd_after_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld |-> $past(frm_stb));
    // R6: data pulses also follow a frame strobe
    p_data_after_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        data_vld |-> $past(frm_stb));
endmodule

// File: tb/test_mon_frame_engine.sv
module test_mon_frame_engine;
    localparam int PER = 20;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       frm_stb;
    logic [7:0] dn_byte;
    logic       dn_eom;
    logic       cmd_vld, cmd_chan_b, data_vld, rsp_rd;
    logic [7:0] cmd_byte, data_byte, up_byte, rsp_data;
    logic       rsp_start, rsp_chan_b;
    logic [3:0] rsp_len;

    always #(PER/2) clk = ~clk;

    mon_frame_engine i_mon_frame_engine (
        .clk(clk), .rst_n(rst_n), .frm_stb(frm_stb), .dn_byte(dn_byte), .dn_eom(dn_eom),
        .cmd_vld(cmd_vld), .cmd_byte(cmd_byte), .cmd_chan_b(cmd_chan_b),
        .data_vld(data_vld), .data_byte(data_byte),
        .rsp_start(rsp_start), .rsp_chan_b(rsp_chan_b), .rsp_len(rsp_len),
        .rsp_data(rsp_data), .rsp_rd(rsp_rd), .up_byte(up_byte)
    );

    // back end reply data source
    logic [7:0] src_mem [0:63];
    int src_ptr = 0;
    assign rsp_data = src_mem[src_ptr[5:0]];
    always @(posedge clk) if (rst_n && rsp_rd) src_ptr <= src_ptr + 1;

    int n_vec = 0, n_bad = 0;
    string tag = "R13";
    bit running = 0;
    bit done = 0;

    task automatic check(input string req, input bit ok, input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, expv);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit         m_held;
    int         m_cand;
    int         m_st;       // 0 start,1 command,2 data,3 id second byte,4 ignore
    bit         m_chan;
    int         m_cnt, m_cap;
    bit         e_cmd_vld, e_chan, e_dv;
    int         e_cmd, e_data, e_up;
    logic [7:0] txq[$];
    bit         m_pend, m_pend_id, m_pend_chan;
    int         m_pend_n, m_ptr;
    bit         idq, start_ok;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_held = 0; m_st = 0; e_cmd_vld = 0; e_dv = 0; e_up = 8'hFF;
            txq.delete(); m_pend = 0; m_ptr = 0;
        end else begin
            e_cmd_vld = 0; e_dv = 0; idq = 0;
            start_ok = !m_pend && (txq.size() == 0);
            if (frm_stb) begin
                if (txq.size() > 0) e_up = txq.pop_front();
                else if (m_pend) begin
                    if (m_pend_id) begin
                        txq.push_back(8'h80); txq.push_back(8'h80);
                        txq.push_back(8'h82); txq.push_back(8'h82);
                    end else begin
                        txq.push_back(m_pend_chan ? 8'h91 : 8'h81);
                        txq.push_back(m_pend_chan ? 8'h91 : 8'h81);
                        for (int k = 0; k < m_pend_n; k++) begin
                            txq.push_back(src_mem[(m_ptr + k) % 64]);
                            txq.push_back(src_mem[(m_ptr + k) % 64]);
                        end
                        m_ptr += m_pend_n;
                    end
                    txq.push_back(8'hFF);
                    m_pend = 0;
                    e_up = txq.pop_front();
                end else e_up = 8'hFF;

                if (dn_eom) begin
                    m_held = 0; m_st = 0;
                end else if (m_held && dn_byte == m_cand) begin
                    m_held = 0;
                    case (m_st)
                        0: if (dn_byte == 8'h81 || dn_byte == 8'h91) begin
                               m_st = 1; m_chan = (dn_byte == 8'h91);
                           end else if (dn_byte == 8'h80) m_st = 3;
                           else m_st = 4;
                        1: if (dn_byte[6:5] == 2'b10) m_st = 4;
                           else begin
                               m_st = 2; e_cmd_vld = 1; e_cmd = dn_byte;
                               e_chan = (dn_byte[6:5] == 2'b01) ? 1'b0 : m_chan;
                               m_cnt = 0; m_cap = (dn_byte[6:5] == 2'b11) ? 16 : 4;
                           end
                        2: if (m_cnt < m_cap) begin
                               e_dv = 1; e_data = dn_byte; m_cnt++;
                           end else m_st = 4;
                        3: begin m_st = 4; idq = (dn_byte == 8'h00); end
                        default: m_st = 4;
                    endcase
                end else begin
                    m_cand = dn_byte; m_held = 1;
                end
            end
            if (idq && !m_pend && txq.size() == 0) begin
                m_pend = 1; m_pend_id = 1;
            end else if (rsp_start && start_ok) begin
                m_pend = 1; m_pend_id = 0; m_pend_chan = rsp_chan_b; m_pend_n = rsp_len + 1;
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && running) begin
            check(tag, cmd_vld == e_cmd_vld, cmd_vld, e_cmd_vld);
            if (e_cmd_vld) begin
                check(tag, cmd_byte == e_cmd[7:0], cmd_byte, e_cmd);
                check(tag, cmd_chan_b == e_chan, cmd_chan_b, e_chan);
            end
            check(tag, data_vld == e_dv, data_vld, e_dv);
            if (e_dv) check(tag, data_byte == e_data[7:0], data_byte, e_data);
            check(tag, up_byte == e_up[7:0], up_byte, e_up);
        end
    end

    // ---------------- stimulus ----------------
    task automatic frame(input logic [7:0] b, input logic eom);
        @(negedge clk); frm_stb = 1'b1; dn_byte = b; dn_eom = eom;
        @(negedge clk); frm_stb = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        frame(b, 1'b0); frame(b, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) frame(8'hFF, 1'b1);
    endtask

    task automatic req_read(input logic ch, input logic [3:0] len);
        @(negedge clk); rsp_start = 1'b1; rsp_chan_b = ch; rsp_len = len;
        @(negedge clk); rsp_start = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(PER * 100000);
        check("watchdog", 1'b0, 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) src_mem[i] = 8'(8'hA0 + i);
        rst_n = 1'b0; frm_stb = 1'b0; dn_byte = 8'hFF; dn_eom = 1'b1;
        rsp_start = 1'b0; rsp_chan_b = 1'b0; rsp_len = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state, R11 idle pattern after reset
        check("R13", cmd_vld == 1'b0, cmd_vld, 0);
        check("R13", data_vld == 1'b0, data_vld, 0);
        check("R11", up_byte == 8'hFF, up_byte, 8'hFF);
        running = 1;
        idle(2);

        // R3: local write on sub-channel A, three data bytes (R6)
        tag = "R3";
        send(8'h81); send(8'h85); send(8'hAA); send(8'h55); send(8'h3C); idle(1);
        // R3: local command on sub-channel B
        send(8'h91); send(8'h84); send(8'h01); idle(1);
        // R4: global command on B reports channel 0
        tag = "R4";
        send(8'h91); send(8'hA2); send(8'h07); idle(1);
        // R6: RAM write with 18 bytes, 16 forwarded
        tag = "R6";
        send(8'h81); send(8'hE0);
        for (int k = 0; k < 18; k++) send(8'(k * 3));
        idle(1);
        // R6: register write with 6 bytes, 4 forwarded
        send(8'h91); send(8'h81);
        for (int k = 0; k < 6; k++) send(8'(8'h40 + k));
        idle(1);
        // R5: reserved command type
        tag = "R5";
        send(8'h81); send(8'hC0); send(8'h12); send(8'h34); idle(1);
        // R2: bad start byte ignores whole message
        tag = "R2";
        send(8'h55); send(8'h81); send(8'h85); send(8'h11); idle(1);
        send(8'h91); send(8'h86); send(8'h22); idle(1);
        // R1: mismatched copies and repeated values
        tag = "R1";
        send(8'h81); send(8'h85);
        frame(8'h11, 0); frame(8'h22, 0); frame(8'h22, 0);
        frame(8'h33, 0); frame(8'h33, 0); frame(8'h33, 0);
        frame(8'h44, 0);
        idle(1);
        send(8'h81); send(8'h85); send(8'h77); send(8'h77); idle(1);
        // R7: end-of-message drops a half pair
        tag = "R7";
        send(8'h81); frame(8'h85, 0); frame(8'h85, 1);
        send(8'h85); send(8'h66); idle(1);
        send(8'h91); send(8'h85); send(8'h21); idle(1);
        // R8: identification request and reply
        tag = "R8";
        send(8'h80); send(8'h00); idle(8);
        send(8'h80); send(8'h01); idle(4);
        // R9: read reply on B with three data bytes
        tag = "R9";
        req_read(1'b1, 4'd2); idle(12);
        // R10: shortest reply, one data byte
        tag = "R10";
        req_read(1'b0, 4'd0); idle(8);
        // R12: second request while pending, third while busy
        tag = "R12";
        req_read(1'b0, 4'd3); req_read(1'b1, 4'd0);
        idle(3);
        req_read(1'b1, 4'd1);
        idle(2);
        send(8'h80); send(8'h00);
        idle(10);
        // R11: reply following a reply has an idle frame between
        tag = "R11";
        req_read(1'b1, 4'd15); idle(3);
        frame(8'hFF, 1);
        idle(34);
        req_read(1'b0, 4'd1); idle(8);
        running = 0;
        @(negedge clk);
        // R9: number of bytes taken from the back end
        check("R9", src_ptr == m_ptr, src_ptr, m_ptr);
        finish_run();
    end
endmodule